// File: doc/BRIEF.md
# Video Sync Slicer and Separator

This block takes lowpass-filtered digital video samples and a slice level, and separates the composite sync by comparison. The first active sample of each sync pulse is timed against an external line counter that runs locked to the incoming video. The block reports a one-cycle horizontal sync pulse and a signed phase error, which a downstream loop filter uses to steer that counter.

An optional acceptance window around the nominal sync position rejects sync edges that fall far from the expected place, so noise inside the active line cannot pull the phase measurement. Rejected edges leave the last good phase error in place and clear a valid flag.

In parallel, an up/down integrator accumulates the sliced sync. Long broad pulses in the vertical interval push it above a programmable threshold, which raises vertical sync. The half of the line in which that happens selects the field flag.

Top module: `vsync_separator`

## Requirements
- R1: Sync is active for a sample strictly below the slice level. A sample equal to or above the level is inactive.
- R2: An inactive-to-active transition of the sliced sync is a falling edge. When the edge is accepted, `hsync_o` is high for exactly one cycle, two clock edges after the first active sample is presented.
- R3: `phase_err_o` is the two's-complement value (line counter at the first active sample) minus `NOM_POS`, CNT_W+1 bits wide. It updates together with `hsync_o`.
- R4: With `win_en_i` high, an edge is accepted only if the error is within ±`WIN_HALF`, both limits inclusive. With `win_en_i` low, every edge is accepted.
- R5: A rejected edge gives no `hsync_o` pulse and keeps the previous `phase_err_o`. It drives `phase_valid_o` to 0 until the next accepted edge sets it to 1.
- R6: The integrator rises by one per cycle of active sync and falls by one otherwise. It saturates at 0 and at 2^INT_W−1 and never wraps.
- R7: `vsync_o` is high exactly when the integrator value is at least `vs_thresh_i`. It is registered one cycle after the integrator, so with an empty integrator and a threshold T it first rises T+2 edges after sync goes active.
- R8: When `vsync_o` rises, `field_o` takes 1 if the line counter at that edge is at least `HALF_LINE` (second field), and 0 otherwise. At all other times `field_o` holds.
- R9: Synchronous active-high reset clears all outputs and empties the integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | SAMPLE_W | Filtered video sample |
| slice_lvl_i | input | SAMPLE_W | Slice level |
| win_en_i | input | 1 | Enable acceptance window |
| line_cnt_i | input | CNT_W | Line counter value |
| vs_thresh_i | input | INT_W | Vertical sync integrator threshold |
| hsync_o | output | 1 | Horizontal sync pulse, one cycle |
| phase_err_o | output | CNT_W+1 | Signed phase error |
| phase_valid_o | output | 1 | Last edge accepted |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | Field flag (1 = second field) |

## Verification
The horizontal pulse and the phase error come two edges after the first active sample. The bench therefore drives the sample at a falling clock edge and holds it for one more cycle. It then reads the outputs at the second falling edge, and reads `hsync_o` once more a cycle later to confirm the pulse has ended. Vertical sync comes a further edge later, since the integrator sits in between. The bench counts falling edges from the point sync starts or stops and checks `vsync_o` just before and just after the predicted cycle: T+1 and T+2 on the way up, and 257−T and 258−T on the way down from saturation.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } int_step_e;

    function automatic logic within_window(input int diff, input int half);
        return (diff <= half) && (diff >= -half);
    endfunction

endpackage

// File: rtl/vsync_slicer.sv
module vsync_slicer #(
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] level_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic                sync_o,
    output logic                fall_o,
    output logic [CNT_W-1:0]    cnt_o
);
    logic             sync_q;
    logic             sync_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            sync_d <= 1'b0;
            cnt_q  <= '0;
        end else begin
            sync_q <= (sample_i < level_i);
            sync_d <= sync_q;
            cnt_q  <= cnt_i;
        end
    end

    assign sync_o = sync_q;
    assign fall_o = sync_q & ~sync_d;
    assign cnt_o  = cnt_q;

    // R2: an edge is never reported two cycles in a row
    p_single_edge_r2: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/vsync_phase_meter.sv
module vsync_phase_meter
    import vsync_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int NOM_POS  = 64,
    parameter int WIN_HALF = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fall_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic                    win_en_i,
    output logic                    hs_o,
    output logic signed [CNT_W:0]   err_o,
    output logic                    valid_o
);
    localparam int ERR_W = CNT_W + 1;
    localparam logic signed [ERR_W-1:0] NOM_S = ERR_W'(NOM_POS);

    logic signed [ERR_W-1:0] diff;
    logic                    in_win;
    logic                    accept;
    logic                    hs_q;
    logic                    valid_q;
    logic signed [ERR_W-1:0] err_q;

    always_comb begin
        diff   = $signed({1'b0, cnt_i}) - NOM_S;
        in_win = within_window(int'(diff), WIN_HALF);
        accept = fall_i & (~win_en_i | in_win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q    <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= '0;
        end else begin
            hs_q <= accept;
            if (fall_i) valid_q <= accept;
            if (accept) err_q   <= diff;
        end
    end

    assign hs_o    = hs_q;
    assign err_o   = err_q;
    assign valid_o = valid_q;

    // R5: a rejected edge leaves the error untouched
    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fall_i && !accept) |=> $stable(err_q));
    // R4: with the window on, a reported error lies inside it
    p_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        (hs_q && $past(win_en_i)) |-> within_window(int'(err_q), WIN_HALF));
    // R5: a pulse always comes with the valid flag
    p_pulse_valid_r5: assert property (@(posedge clk) disable iff (rst)
        hs_q |-> valid_q);
endmodule

// File: rtl/vsync_integrator.sv
module vsync_integrator
    import vsync_pkg::*;
#(
    parameter int INT_W     = 8,
    parameter int CNT_W     = 10,
    parameter int HALF_LINE = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic [INT_W-1:0] thresh_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             vsync_o,
    output logic             field_o
);
    localparam logic [INT_W-1:0] ACC_MAX = '1;
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF_LINE);

    logic [INT_W-1:0] acc_q;
    logic             vs_q;
    logic             field_q;
    logic             above;
    int_step_e        step;

    always_comb begin
        if (sync_i) step = (acc_q == ACC_MAX) ? STEP_HOLD : STEP_UP;
        else        step = (acc_q == '0)      ? STEP_HOLD : STEP_DOWN;
        above = (acc_q >= thresh_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            vs_q    <= 1'b0;
            field_q <= 1'b0;
        end else begin
            case (step)
                STEP_UP:   acc_q <= acc_q + INT_W'(1);
                STEP_DOWN: acc_q <= acc_q - INT_W'(1);
                default:   acc_q <= acc_q;
            endcase
            vs_q <= above;
            if (above && !vs_q) field_q <= (cnt_i >= HALF_C);
        end
    end

    assign vsync_o = vs_q;
    assign field_o = field_q;

    // R6: saturation at the top
    p_sat_top_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_MAX && sync_i) |=> acc_q == ACC_MAX);
    // R6: saturation at the bottom
    p_sat_floor_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_q == '0 && !sync_i) |=> acc_q == '0);
    // R8: field changes only as vertical sync rises
    p_field_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_q) |-> $rose(vs_q));
endmodule

// File: rtl/vsync_separator.sv
module vsync_separator #(
    parameter int SAMPLE_W  = 8,
    parameter int CNT_W     = 10,
    parameter int INT_W     = 8,
    parameter int NOM_POS   = 64,
    parameter int WIN_HALF  = 16,
    parameter int HALF_LINE = 512
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SAMPLE_W-1:0]   sample_i,
    input  logic [SAMPLE_W-1:0]   slice_lvl_i,
    input  logic                  win_en_i,
    input  logic [CNT_W-1:0]      line_cnt_i,
    input  logic [INT_W-1:0]      vs_thresh_i,
    output logic                  hsync_o,
    output logic signed [CNT_W:0] phase_err_o,
    output logic                  phase_valid_o,
    output logic                  vsync_o,
    output logic                  field_o
);
    logic             sync_s;
    logic             fall_s;
    logic [CNT_W-1:0] cnt_s;

    vsync_slicer #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_slicer (
        .clk(clk), .rst(rst), .sample_i(sample_i), .level_i(slice_lvl_i),
        .cnt_i(line_cnt_i), .sync_o(sync_s), .fall_o(fall_s), .cnt_o(cnt_s)
    );

    vsync_phase_meter #(.CNT_W(CNT_W), .NOM_POS(NOM_POS), .WIN_HALF(WIN_HALF)) u_phase (
        .clk(clk), .rst(rst), .fall_i(fall_s), .cnt_i(cnt_s), .win_en_i(win_en_i),
        .hs_o(hsync_o), .err_o(phase_err_o), .valid_o(phase_valid_o)
    );

    vsync_integrator #(.INT_W(INT_W), .CNT_W(CNT_W), .HALF_LINE(HALF_LINE)) u_integ (
        .clk(clk), .rst(rst), .sync_i(sync_s), .thresh_i(vs_thresh_i),
        .cnt_i(line_cnt_i), .vsync_o(vsync_o), .field_o(field_o)
    );

    // R2: the horizontal pulse lasts one cycle
    p_hs_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        hsync_o |=> !hsync_o);
endmodule

// File: tb/tb_vsync_separator.sv
module tb_vsync_separator;
    localparam int T_VS = 20;
    localparam logic [7:0] HI = 8'd200;
    localparam logic [7:0] LO = 8'd10;
    localparam logic [7:0] SL = 8'd100;
    localparam int VEC_N = 10;
    localparam int V_POS [VEC_N] = '{64, 70, 80, 81, 48, 47, 200, 10, 47, 990};
    localparam int V_WIN [VEC_N] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 0};
    localparam int V_ACC [VEC_N] = '{1, 1, 1, 0, 1, 0, 1, 1, 0, 1};
    localparam int V_ERR [VEC_N] = '{0, 6, 16, 16, -16, -16, 136, -54, -54, 926};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sample = 8'd200;
    logic [7:0]  slice = 8'd100;
    logic        win_en = 1'b0;
    logic [9:0]  line_cnt = '0;
    logic [7:0]  thresh = 8'(T_VS);
    logic        hsync, pvalid, vsync, field;
    logic signed [10:0] perr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vsync_separator dut (
        .clk(clk), .rst(rst), .sample_i(sample), .slice_lvl_i(slice),
        .win_en_i(win_en), .line_cnt_i(line_cnt), .vs_thresh_i(thresh),
        .hsync_o(hsync), .phase_err_o(perr), .phase_valid_o(pvalid),
        .vsync_o(vsync), .field_o(field)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] s, input int c);
        @(negedge clk);
        sample   = s;
        line_cnt = 10'(c);
    endtask

    task automatic do_reset(input int c);
        @(negedge clk);
        rst = 1'b1; sample = HI; line_cnt = 10'(c);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int last_err;
        int last_valid;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(int'(hsync), 0, "R9 hsync");
        chk(int'(perr), 0, "R9 phase_err");
        chk(int'(pvalid), 0, "R9 valid");
        chk(int'(vsync), 0, "R9 vsync");
        chk(int'(field), 0, "R9 field");
        rst = 1'b0;
        last_err = 0;
        last_valid = 0;

        // R2 R3 R4 R5: vector walk
        for (int i = 0; i < VEC_N; i++) begin
            repeat (4) step(HI, V_POS[i] - 5);
            win_en = V_WIN[i][0];
            step(LO, V_POS[i]);
            step(LO, V_POS[i] + 1);
            if (V_ACC[i] != 0) begin
                last_err = V_ERR[i];
                last_valid = 1;
            end else begin
                last_valid = 0;
            end
            @(negedge clk);
            chk(int'(hsync), V_ACC[i], "R2 R4 hsync pulse");
            chk(int'(perr), last_err, "R3 R5 phase error");
            chk(int'(pvalid), last_valid, "R5 valid flag");
            @(negedge clk);
            chk(int'(hsync), 0, "R2 pulse width");
        end

        // R1: sample equal to slice level is not sync
        win_en = 1'b0;
        repeat (4) step(HI, 30);
        step(SL, 64);
        step(SL, 65);
        @(negedge clk);
        chk(int'(hsync), 0, "R1 equal level no edge");
        chk(int'(perr), last_err, "R1 error unchanged");

        // R6 R7 R8: vertical integration, second half of the line
        do_reset(600);
        repeat (5) @(negedge clk);
        chk(int'(vsync), 0, "R6 floor no wrap");
        sample = LO;
        repeat (T_VS + 1) @(negedge clk);
        chk(int'(vsync), 0, "R7 before threshold");
        @(negedge clk);
        chk(int'(vsync), 1, "R7 at threshold");
        chk(int'(field), 1, "R8 second field");
        repeat (300) @(negedge clk);
        line_cnt = 10'd100;
        @(negedge clk);
        chk(int'(field), 1, "R8 field held");
        sample = HI;
        repeat (257 - T_VS) @(negedge clk);
        chk(int'(vsync), 1, "R6 saturated decay still above");
        @(negedge clk);
        chk(int'(vsync), 0, "R6 R7 saturated decay falls");

        // R8: first half of the line
        do_reset(100);
        sample = LO;
        repeat (T_VS + 2) @(negedge clk);
        chk(int'(vsync), 1, "R7 rise");
        chk(int'(field), 0, "R8 first field");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule